// File: doc/BRIEF.md
# Region Conflict Detection Unit

This unit watches the memory traffic of a few hardware threads and traps when two threads race inside regions that were live at the same time. A region is the span of one thread's accesses between two fence events. Each thread keeps a small, fixed-size set of the word addresses its current region has touched, with a read flag and a write flag per entry. A closed region's set is kept while any other thread still has a region open that began before it closed.

Every fence that ends a region gets a number from one global counter. Fences that arrive on the same cycle are numbered in ascending thread index. The start and end numbers of regions decide whether two regions overlapped. A bounding fence may be absorbed, which merges the regions on both sides of it, when the region's set still has a free entry after that cycle's access. The unit only detects and reports: a conflict sets a sticky exception carrying both thread indices and the word address, and nothing is replayed or rolled back.

Top module: `rcd_unit`

## Requirements
- R1: After a synchronous active-high reset, `exc` and `ovf` are 0 and `fence_seq` is 0, and all address sets and region numbers are cleared.
- R2: An access by thread A that hits a word already touched by the open region of another thread B, with at least one of the two a write, sets `exc` on the next clock edge with `exc_tid_a` = A, `exc_tid_b` = B and `exc_addr` = the access address with bits [1:0] cleared.
- R3: Two reads of the same word never conflict, and accesses by a single thread never conflict with each other.
- R4: A region of thread B that closed before the current region of thread A opened (its end number is below A's start number) never causes a conflict with A.
- R5: A closed region of thread B whose end number is above the start number of A's open region is still checked, so an access by A to a word that region wrote raises `exc`.
- R6: Addresses are compared as words. Addresses that differ only in bits [1:0] match, and addresses that differ in any higher bit do not.
- R7: Each fence that closes a region takes the next number in the global order, starting at 1, and `fence_seq` shows the last number taken. Fences closing on the same cycle are numbered in ascending thread index, so the lower-index thread's region ends before the higher-index thread's new region starts.
- R8: A regular fence (`fence_bnd` = 0) always closes the region. A bounding fence (`fence_bnd` = 1) is absorbed, and takes no number, when the set has a free entry after that cycle's access. It closes the region when the set is full.
- R9: Once set, `exc`, `exc_tid_a`, `exc_tid_b` and `exc_addr` hold until reset, and later conflicts do not change them.
- R10: `ovf` is a sticky flag, separate from `exc`, that goes to 1 when a new word arrives at a full set, or when a fence closes a region while the thread's retained closed set still overlaps another thread's open region. It does not set `exc`.
- R11: When several conflicts are found on one cycle, including two threads touching the same word on the same cycle, the one reported has the lowest accessing thread, then the lowest other thread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | NT | Per-thread access valid |
| acc_addr | input | NT x ADDR_W | Per-thread byte address |
| acc_wr | input | NT | Per-thread access is a write (0 = read) |
| fence_vld | input | NT | Per-thread fence event; an access on the same cycle belongs to the region before the fence |
| fence_bnd | input | NT | Fence type: 1 = bounding, 0 = regular |
| exc | output | 1 | Sticky conflict exception |
| exc_tid_a | output | TID_W | Thread whose access found the conflict |
| exc_tid_b | output | TID_W | Thread owning the other region |
| exc_addr | output | ADDR_W | Word-aligned conflicting address |
| ovf | output | 1 | Sticky tracking overflow |
| fence_seq | output | SEQ_W | Last number taken in the global fence order |

## Verification
A wrong start or end number in a thread's state shows at the ports as a conflict that appears or goes missing on the first access after the fences concerned. That makes ordering faults visible one cycle after the access that exposes them. A set entry with a wrong flag or a wrong word shows the same way, as a missed or spurious `exc` one clock after the matching access. Retention faults show up later, after another thread's fence: a set freed too early hides a conflict, and a set kept too long raises `ovf` on the owner's next fence. Numbering faults show directly in `fence_seq` one edge after the fence.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
    parameter int ADDR_W = 16;
    parameter int SEQ_W  = 16;
    parameter int CAP    = 4;
    localparam int WORD_W = ADDR_W - 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEQ_W-1:0]  seq_t;

    typedef struct packed {
        logic  vld;
        word_t word;
        logic  rd;
        logic  wr;
    } entry_t;

    typedef entry_t [CAP-1:0] rset_t;

    function automatic word_t word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:2];
    endfunction

    function automatic logic set_clash(input rset_t s, input word_t w, input logic is_wr);
        logic h;
        h = 1'b0;
        for (int k = 0; k < CAP; k++)
            if (s[k].vld && s[k].word == w && (s[k].wr || is_wr)) h = 1'b1;
        return h;
    endfunction
endpackage

// File: rtl/rcd_region_set.sv
module rcd_region_set
    import rcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acc_vld,
    input  word_t acc_word,
    input  logic  acc_wr,
    input  logic  fence_vld,
    input  logic  fence_bnd,
    input  seq_t  fence_num,
    input  logic  keep_prev,
    output logic  close,
    output rset_t cur_set,
    output rset_t prev_set,
    output logic  prev_live,
    output seq_t  prev_end,
    output seq_t  start,
    output logic  ovf_ev
);
    rset_t cur_upd;
    logic  hit, placed, drop, free_after;

    always_comb begin
        cur_upd = cur_set;
        hit     = 1'b0;
        placed  = 1'b0;
        drop    = 1'b0;
        if (acc_vld) begin
            for (int k = 0; k < CAP; k++) begin
                if (cur_set[k].vld && cur_set[k].word == acc_word) begin
                    hit = 1'b1;
                    if (acc_wr) cur_upd[k].wr = 1'b1;
                    else        cur_upd[k].rd = 1'b1;
                end
            end
            if (!hit) begin
                for (int k = 0; k < CAP; k++) begin
                    if (!placed && !cur_set[k].vld) begin
                        cur_upd[k] = '{vld: 1'b1, word: acc_word, rd: !acc_wr, wr: acc_wr};
                        placed = 1'b1;
                    end
                end
                drop = !placed;
            end
        end
        free_after = 1'b0;
        for (int k = 0; k < CAP; k++)
            if (!cur_upd[k].vld) free_after = 1'b1;
    end

    assign close  = fence_vld && !(fence_bnd && free_after);
    assign ovf_ev = drop || (close && prev_live && keep_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_set   <= '0;
            prev_set  <= '0;
            prev_live <= 1'b0;
            prev_end  <= '0;
            start     <= '0;
        end else if (close) begin
            prev_set  <= cur_upd;
            prev_live <= 1'b1;
            prev_end  <= fence_num;
            start     <= fence_num;
            cur_set   <= '0;
        end else begin
            cur_set <= cur_upd;
            if (prev_live && !keep_prev) prev_live <= 1'b0;
        end
    end
endmodule

// File: rtl/rcd_fence_order.sv
module rcd_fence_order
    import rcd_pkg::*;
#(
    parameter int NT = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NT-1:0]            fire,
    output logic [NT-1:0][SEQ_W-1:0] num,
    output logic [SEQ_W-1:0]         count
);
    seq_t run;

    always_comb begin
        run = count;
        for (int i = 0; i < NT; i++) begin
            if (fire[i]) run = run + 1'b1;
            num[i] = run;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= run;
    end
endmodule

// File: rtl/rcd_unit.sv
module rcd_unit
    import rcd_pkg::*;
#(
    parameter  int NT    = 3,
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NT-1:0]             acc_vld,
    input  logic [NT-1:0][ADDR_W-1:0] acc_addr,
    input  logic [NT-1:0]             acc_wr,
    input  logic [NT-1:0]             fence_vld,
    input  logic [NT-1:0]             fence_bnd,
    output logic                      exc,
    output logic [TID_W-1:0]          exc_tid_a,
    output logic [TID_W-1:0]          exc_tid_b,
    output logic [ADDR_W-1:0]         exc_addr,
    output logic                      ovf,
    output logic [SEQ_W-1:0]          fence_seq
);
    word_t                   word      [NT];
    rset_t                   cur_set   [NT];
    rset_t                   prev_set  [NT];
    seq_t                    prev_end  [NT];
    seq_t                    start     [NT];
    logic [NT-1:0]           prev_live, keep_prev, close, ovf_ev;
    logic [NT-1:0][SEQ_W-1:0] num;

    rcd_fence_order #(.NT(NT)) u_order (
        .clk(clk), .rst(rst), .fire(close), .num(num), .count(fence_seq)
    );

    for (genvar g = 0; g < NT; g++) begin : g_thr
        assign word[g] = word_of(acc_addr[g]);
        rcd_region_set u_set (
            .clk(clk), .rst(rst),
            .acc_vld(acc_vld[g]), .acc_word(word[g]), .acc_wr(acc_wr[g]),
            .fence_vld(fence_vld[g]), .fence_bnd(fence_bnd[g]), .fence_num(num[g]),
            .keep_prev(keep_prev[g]), .close(close[g]),
            .cur_set(cur_set[g]), .prev_set(prev_set[g]), .prev_live(prev_live[g]),
            .prev_end(prev_end[g]), .start(start[g]), .ovf_ev(ovf_ev[g])
        );
    end

    // A retained set stays needed while another thread's open region began before it closed.
    always_comb begin
        for (int j = 0; j < NT; j++) begin
            keep_prev[j] = 1'b0;
            for (int k = 0; k < NT; k++)
                if (k != j && start[k] < prev_end[j]) keep_prev[j] = 1'b1;
        end
    end

    logic              found;
    logic [TID_W-1:0]  fa, fb;
    logic [ADDR_W-1:0] faddr;

    always_comb begin : find_blk
        logic hit_ij;
        found = 1'b0;
        fa    = '0;
        fb    = '0;
        faddr = '0;
        for (int i = 0; i < NT; i++) begin
            for (int j = 0; j < NT; j++) begin
                hit_ij = 1'b0;
                if (acc_vld[i] && i != j) begin
                    if (set_clash(cur_set[j], word[i], acc_wr[i])) hit_ij = 1'b1;
                    if (prev_live[j] && prev_end[j] > start[i]
                        && set_clash(prev_set[j], word[i], acc_wr[i])) hit_ij = 1'b1;
                    if (acc_vld[j] && word[j] == word[i] && (acc_wr[i] || acc_wr[j])) hit_ij = 1'b1;
                end
                if (hit_ij && !found) begin
                    found = 1'b1;
                    fa    = TID_W'(i);
                    fb    = TID_W'(j);
                    faddr = {word[i], 2'b00};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exc       <= 1'b0;
            exc_tid_a <= '0;
            exc_tid_b <= '0;
            exc_addr  <= '0;
            ovf       <= 1'b0;
        end else begin
            if (!exc && found) begin
                exc       <= 1'b1;
                exc_tid_a <= fa;
                exc_tid_b <= fb;
                exc_addr  <= faddr;
            end
            if (|ovf_ev) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/rcd_unit_checker.sv
module rcd_unit_checker
    import rcd_pkg::*;
#(
    parameter  int NT    = 3,
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NT-1:0]             fence_vld,
    input logic [NT-1:0]             fence_bnd,
    input logic                      exc,
    input logic [TID_W-1:0]          exc_tid_a,
    input logic [TID_W-1:0]          exc_tid_b,
    input logic [ADDR_W-1:0]         exc_addr,
    input logic                      ovf,
    input logic [SEQ_W-1:0]          fence_seq
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!exc && !ovf && fence_seq == '0));

    a_r9_exc_sticky: assert property (@(posedge clk) disable iff (rst)
        exc |=> (exc && $stable(exc_tid_a) && $stable(exc_tid_b) && $stable(exc_addr)));

    a_r3_distinct_threads: assert property (@(posedge clk) disable iff (rst)
        exc |-> (exc_tid_a != exc_tid_b));

    a_r6_word_aligned: assert property (@(posedge clk) disable iff (rst)
        exc |-> (exc_addr[1:0] == 2'b00));

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    a_r8_regular_closes: assert property (@(posedge clk) disable iff (rst)
        |(fence_vld & ~fence_bnd) |=> (fence_seq != $past(fence_seq)));

    a_r7_seq_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fence_seq - $past(fence_seq)) <= SEQ_W'(NT)));
endmodule

bind rcd_unit rcd_unit_checker #(.NT(NT)) u_chk (
    .clk(clk), .rst(rst), .fence_vld(fence_vld), .fence_bnd(fence_bnd),
    .exc(exc), .exc_tid_a(exc_tid_a), .exc_tid_b(exc_tid_b), .exc_addr(exc_addr),
    .ovf(ovf), .fence_seq(fence_seq)
);

// File: tb/rcd_unit_test.sv
`timescale 1ns/1ps
module rcd_unit_test;
    localparam int NT = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NT-1:0]    acc_vld = '0, acc_wr = '0, fence_vld = '0, fence_bnd = '0;
    logic [NT-1:0][15:0] acc_addr = '0;
    logic             exc, ovf;
    logic [1:0]       exc_tid_a, exc_tid_b;
    logic [15:0]      exc_addr, fence_seq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rcd_unit #(.NT(NT)) uut (
        .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .fence_vld(fence_vld), .fence_bnd(fence_bnd), .exc(exc), .exc_tid_a(exc_tid_a),
        .exc_tid_b(exc_tid_b), .exc_addr(exc_addr), .ovf(ovf), .fence_seq(fence_seq)
    );

    typedef struct packed {
        logic [2:0]  v, w, f, b;
        logic [15:0] a2, a1, a0;
        logic        e;
        logic [15:0] s;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TAB [NV] = '{
        '{3'b001, 3'b001, 3'b000, 3'b000, 16'h0,   16'h0,   16'h100, 1'b0, 16'd0}, // R2 setup: T0 writes
        '{3'b110, 3'b000, 3'b000, 3'b000, 16'h300, 16'h200, 16'h0,   1'b0, 16'd0}, // R3 reads elsewhere
        '{3'b010, 3'b000, 3'b000, 3'b000, 16'h0,   16'h104, 16'h0,   1'b0, 16'd0}, // R6 next word
        '{3'b000, 3'b000, 3'b001, 3'b000, 16'h0,   16'h0,   16'h0,   1'b0, 16'd1}, // R8 regular fence
        '{3'b000, 3'b000, 3'b110, 3'b000, 16'h0,   16'h0,   16'h0,   1'b0, 16'd3}, // R7 two fences
        '{3'b000, 3'b000, 3'b000, 3'b000, 16'h0,   16'h0,   16'h0,   1'b0, 16'd3},
        '{3'b010, 3'b010, 3'b000, 3'b000, 16'h0,   16'h100, 16'h0,   1'b0, 16'd3}, // R4 disjoint in time
        '{3'b100, 3'b000, 3'b000, 3'b000, 16'h102, 16'h0,   16'h0,   1'b1, 16'd3}  // R2 conflict
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        acc_vld = '0; acc_wr = '0; fence_vld = '0; fence_bnd = '0; acc_addr = '0;
    endtask

    task automatic do_reset();
        clear_in();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic acc(input int t, input logic [15:0] a, input logic w);
        acc_vld[t] = 1'b1; acc_addr[t] = a; acc_wr[t] = w;
        @(negedge clk);
        clear_in();
    endtask

    task automatic acc2(input int t, input logic [15:0] a, input logic w,
                        input int u, input logic [15:0] b, input logic x);
        acc_vld[t] = 1'b1; acc_addr[t] = a; acc_wr[t] = w;
        acc_vld[u] = 1'b1; acc_addr[u] = b; acc_wr[u] = x;
        @(negedge clk);
        clear_in();
    endtask

    task automatic fen(input logic [2:0] f, input logic [2:0] b);
        fence_vld = f; fence_bnd = b;
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 exc", exc, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 fence_seq", fence_seq, 0);

        for (int n = 0; n < NV; n++) begin
            acc_vld = TAB[n].v; acc_wr = TAB[n].w; fence_vld = TAB[n].f; fence_bnd = TAB[n].b;
            acc_addr[0] = TAB[n].a0; acc_addr[1] = TAB[n].a1; acc_addr[2] = TAB[n].a2;
            @(negedge clk);
            clear_in();
            chk($sformatf("R2/R4/R7 row %0d exc", n), exc, TAB[n].e);
            chk($sformatf("R7/R8 row %0d seq", n), fence_seq, TAB[n].s);
        end
        chk("R2 tid_a", exc_tid_a, 2);
        chk("R2 tid_b", exc_tid_b, 1);
        chk("R2 addr", exc_addr, 16'h100);

        // R3: read-read and same-thread traffic
        do_reset();
        acc2(0, 16'h40, 1'b0, 1, 16'h40, 1'b0);
        acc(0, 16'h80, 1'b1);
        acc(0, 16'h80, 1'b0);
        acc(0, 16'h80, 1'b1);
        chk("R3 no exc", exc, 0);

        // R5: retained closed region still overlaps
        do_reset();
        acc(1, 16'h20, 1'b1);
        fen(3'b010, 3'b000);
        acc(0, 16'h20, 1'b0);
        chk("R5 exc", exc, 1);
        chk("R5 tid_a", exc_tid_a, 0);
        chk("R5 tid_b", exc_tid_b, 1);

        // R7: same-cycle fences numbered by thread index
        do_reset();
        acc2(0, 16'h60, 1'b1, 1, 16'h70, 1'b1);
        fen(3'b011, 3'b000);
        chk("R7 seq", fence_seq, 2);
        acc(1, 16'h60, 1'b0);
        chk("R7 lower thread closed first", exc, 0);
        acc(0, 16'h70, 1'b0);
        chk("R7 higher thread closed later", exc, 1);
        chk("R7 addr", exc_addr, 16'h70);

        // R8: bounding fence merge versus close
        do_reset();
        acc(0, 16'h0, 1'b1);
        fen(3'b001, 3'b001);
        chk("R8 merged", fence_seq, 0);
        acc(0, 16'h10, 1'b1);
        acc(0, 16'h20, 1'b1);
        acc(0, 16'h30, 1'b1);
        fen(3'b001, 3'b001);
        chk("R8 full closes", fence_seq, 1);
        fen(3'b001, 3'b000);
        chk("R8 regular closes", fence_seq, 2);

        // R10: overflow of a full set
        do_reset();
        acc(2, 16'h0, 1'b1);
        acc(2, 16'h4, 1'b1);
        acc(2, 16'h8, 1'b1);
        acc(2, 16'hC, 1'b1);
        chk("R10 not yet", ovf, 0);
        acc(2, 16'h10, 1'b1);
        chk("R10 full ovf", ovf, 1);
        chk("R10 no exc", exc, 0);

        // R10: retained set displaced while still needed
        do_reset();
        acc(0, 16'h0, 1'b1);
        fen(3'b001, 3'b000);
        chk("R10 first fence", ovf, 0);
        fen(3'b001, 3'b000);
        chk("R10 retention ovf", ovf, 1);

        // R11 and R9: same-cycle conflict, then sticky
        do_reset();
        acc2(1, 16'h44, 1'b1, 2, 16'h44, 1'b0);
        chk("R11 exc", exc, 1);
        chk("R11 tid_a", exc_tid_a, 1);
        chk("R11 tid_b", exc_tid_b, 2);
        acc2(0, 16'h80, 1'b1, 1, 16'h80, 1'b1);
        chk("R9 exc held", exc, 1);
        chk("R9 tid_a held", exc_tid_a, 1);
        chk("R9 addr held", exc_addr, 16'h44);

        // R6: low address bits ignored
        do_reset();
        acc(0, 16'h103, 1'b1);
        acc(1, 16'h101, 1'b0);
        chk("R6 exc", exc, 1);
        chk("R6 addr", exc_addr, 16'h100);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule